// File: doc/BRIEF.md
# Oversampled Burst-Mode Bit Recovery

This block turns a stream of blind samples into recovered bits without any clock recovery loop. The sampling front end delivers one word of five samples for every bit period, taken at five times the bit rate with no fixed relation to the sender's bit edges. The block counts, for every sample gap, how often the data toggles across that gap during a window of accepted words. When the window closes it picks the sample farthest from the busiest gap, which is the one nearest the bit centre, and uses that sample for the following window.

Because the choice is redone at every window boundary, a burst from a new sender with its own phase is followed as soon as one window of its training pattern has passed. When the chosen sample moves across the edge of the word, the block gives out zero or two bits for that word, so the stream loses no bit and repeats none. A count field says how many of the two output bit lanes are meaningful. A burst-start pulse wipes the gathered statistics so that a new sender's first window is not skewed by the previous one.

Top module: `os_burst_rx`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0, `out_cnt` and `out_bits` are 0, and `samp_phase` is OSR/2 (2 for five samples).
- R2: Sample `samp[0]` is the earliest in time and `samp[OSR-1]` the latest. For a word that yields one bit, `out_bits[0]` equals `samp[samp_phase]` of that word.
- R3: A toggle between `samp[k]` and `samp[k+1]` adds one vote to gap k (k = 0 to OSR-2). A toggle between the last sample of the previous accepted word and `samp[0]` of the current word adds one vote to gap OSR-1; no vote goes to that gap for the first word after reset or burst start.
- R4: Every WIN accepted words form a window. At its last word the gap e with the most votes (the lowest index on a tie) sets the new phase to (e + (OSR+1)/2) mod OSR, that is (e+3) mod 5. The new phase applies from the next accepted word, and the votes restart from zero.
- R5: If a window holds no votes at all, `samp_phase` keeps its value.
- R6: If the phase used for a word is lower than the phase used for the previous word by more than OSR/2, the word yields no bit (`out_cnt` = 0).
- R7: If the phase used for a word is higher than the phase used for the previous word by more than OSR/2, the word yields two bits (`out_cnt` = 2): `out_bits[0]` is the previous word's sample at the new phase and `out_bits[1]` is the current word's sample at the new phase.
- R8: In every other case an accepted word yields exactly one bit (`out_cnt` = 1), and `out_cnt` never exceeds 2.
- R9: A cycle with `burst_start` high clears the votes, the window position and the link to the previous word, sets `samp_phase` to OSR/2 on the next cycle, and discards that cycle's word, so `out_valid` is 0 on the next cycle.
- R10: Output bit lanes at or above `out_cnt` read 0.
- R11: Each accepted word (`samp_valid` high, `burst_start` low) gives `out_valid` high exactly one cycle later; a cycle without an accepted word gives `out_valid` low, `out_cnt` 0 and `out_bits` 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock, one word per bit period |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_start | input | 1 | Clears the statistics for a new burst; the word of that cycle is dropped |
| samp_valid | input | 1 | `samp` holds a word this cycle |
| samp | input | OSR | Blind samples of one bit period, bit 0 earliest |
| out_valid | output | 1 | A word was processed in the previous cycle |
| out_cnt | output | 2 | Number of recovered bits, 0 to 2 |
| out_bits | output | 2 | Recovered bits, lane 0 first in time |
| samp_phase | output | $clog2(OSR) | Sample index used for the next word |

## Verification
The bench builds the block with five samples per bit and a window of 8 words, so a window closes every eight accepted words and dozens of phase decisions fall within a short run. With bits stretched to six or shrunk to four samples every seventh bit, the chosen phase walks around the word within a few hundred words, which brings both the no-bit and the two-bit wrap cases into reach in each direction. Short windows also let the bench train five bursts, one per starting offset, and an all-ones stretch long enough to hold a full window with no toggle.

// File: rtl/os_burst_pkg.sv
`timescale 1ns/1ps
// Shared types for the oversampled burst receiver.
package os_burst_pkg;
    // Number of bits emitted for one sample word (0, 1 or 2).
    typedef logic [1:0] emit_cnt_t;
    localparam emit_cnt_t EMIT_NONE = 2'd0;
    localparam emit_cnt_t EMIT_ONE  = 2'd1;
    localparam emit_cnt_t EMIT_TWO  = 2'd2;
endpackage

// File: rtl/osbr_edge_vote.sv
`timescale 1ns/1ps
// Edge voting: counts toggles per sample gap over a window of words.
// Assumes: take is high only for an accepted word; clr has priority.
// tally is the vote count including the current word's toggles.
module osbr_edge_vote #(
    parameter int OSR = 5,
    parameter int WIN = 32,
    localparam int VW = $clog2(WIN + 1),
    localparam int CW = $clog2(WIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     take,
    input  logic [OSR-1:0]           word,
    output logic                     win_end,
    output logic [OSR-1:0][VW-1:0]   tally
);
    logic [OSR-1:0]          edge_hit;
    logic [OSR-1:0][VW-1:0]  votes_q;
    logic [CW-1:0]           win_q;
    logic                    last_q;
    logic                    last_ok;

    // Toggles inside the word, one per adjacent sample pair.
    genvar k;
    generate
        for (k = 0; k < OSR - 1; k++) begin : g_inner
            assign edge_hit[k] = word[k] ^ word[k+1];
        end
    endgenerate
    // Toggle across the word boundary, only when a previous word exists.
    assign edge_hit[OSR-1] = last_ok & (last_q ^ word[0]);

    // Running tally including this word.
    always_comb begin
        for (int i = 0; i < OSR; i++) begin
            tally[i] = votes_q[i] + {{(VW-1){1'b0}}, edge_hit[i] & take};
        end
    end

    assign win_end = take && (win_q == CW'(WIN - 1));

    // Vote registers, window position and boundary sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            votes_q <= '0;
            win_q   <= '0;
            last_q  <= 1'b0;
            last_ok <= 1'b0;
        end else if (take) begin
            last_q  <= word[OSR-1];
            last_ok <= 1'b1;
            if (win_end) begin
                votes_q <= '0;
                win_q   <= '0;
            end else begin
                votes_q <= tally;
                win_q   <= win_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osbr_phase_pick.sv
`timescale 1ns/1ps
// Phase selection: at a window end, picks the sample opposite the busiest gap.
// Assumes: tally already includes the closing word; ties go to the lower gap.
module osbr_phase_pick #(
    parameter int OSR = 5,
    parameter int WIN = 32,
    localparam int VW = $clog2(WIN + 1),
    localparam int PW = $clog2(OSR),
    localparam int OFF = (OSR + 1) / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     win_end,
    input  logic [OSR-1:0][VW-1:0]   tally,
    output logic [PW-1:0]            phase
);
    logic [PW-1:0] best_gap;
    logic [VW-1:0] best_val;
    logic [PW-1:0] next_phase;
    int            sum;

    // Busiest gap, lowest index wins a tie.
    always_comb begin
        best_gap = '0;
        best_val = tally[0];
        for (int i = 1; i < OSR; i++) begin
            if (tally[i] > best_val) begin
                best_val = tally[i];
                best_gap = PW'(i);
            end
        end
    end

    // Sample half a bit away from that gap, modulo OSR.
    always_comb begin
        sum = int'(best_gap) + OFF;
        if (sum >= OSR) sum = sum - OSR;
        next_phase = (best_val != '0) ? PW'(sum) : phase;
    end

    // Phase register, refreshed only at a window end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= PW'(OSR / 2);
        end else if (win_end) begin
            phase <= next_phase;
        end
    end
endmodule

// File: rtl/osbr_bit_emit.sv
`timescale 1ns/1ps
// Bit emission: samples the word at the phase and repairs phase wraps.
// Assumes: phase only changes between accepted words; previous word is held.
module osbr_bit_emit
    import os_burst_pkg::*;
#(
    parameter int OSR = 5,
    localparam int PW = $clog2(OSR),
    localparam int HALF = OSR / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            take,
    input  logic [OSR-1:0]  word,
    input  logic [PW-1:0]   phase,
    output logic            out_valid,
    output emit_cnt_t       out_cnt,
    output logic [1:0]      out_bits
);
    logic [PW-1:0]  used_q;
    logic [OSR-1:0] prev_q;
    logic           wrap_fwd;
    logic           wrap_bwd;
    emit_cnt_t      cnt_d;
    logic [1:0]     bits_d;

    // Wrap direction relative to the phase of the previous word.
    assign wrap_fwd = (phase < used_q) && ((used_q - phase) > PW'(HALF));
    assign wrap_bwd = (phase > used_q) && ((phase - used_q) > PW'(HALF));

    // Bits for this word.
    always_comb begin
        if (wrap_fwd) begin
            cnt_d  = EMIT_NONE;
            bits_d = 2'b00;
        end else if (wrap_bwd) begin
            cnt_d  = EMIT_TWO;
            bits_d = {word[phase], prev_q[phase]};
        end else begin
            cnt_d  = EMIT_ONE;
            bits_d = {1'b0, word[phase]};
        end
    end

    // Output registers and previous-word history.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            used_q    <= PW'(HALF);
            prev_q    <= '0;
            out_valid <= 1'b0;
            out_cnt   <= EMIT_NONE;
            out_bits  <= 2'b00;
        end else begin
            out_valid <= take;
            out_cnt   <= take ? cnt_d : EMIT_NONE;
            out_bits  <= take ? bits_d : 2'b00;
            if (take) begin
                used_q <= phase;
                prev_q <= word;
            end
        end
    end
endmodule

// File: rtl/os_burst_rx.sv
`timescale 1ns/1ps
// Oversampled burst receiver top: votes on toggle positions over a window,
// picks the centre sample for the next window, and emits 0..2 bits per word.
// Assumes: one OSR-sample word per bit period, bit 0 earliest; bursts are
// preceded by a toggling training pattern of at least one full window.
module os_burst_rx
    import os_burst_pkg::*;
#(
    parameter int OSR = 5,
    parameter int WIN = 32,
    localparam int PW = $clog2(OSR),
    localparam int VW = $clog2(WIN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            burst_start,
    input  logic            samp_valid,
    input  logic [OSR-1:0]  samp,
    output logic            out_valid,
    output logic [1:0]      out_cnt,
    output logic [1:0]      out_bits,
    output logic [PW-1:0]   samp_phase
);
    logic                   take;
    logic                   win_end;
    logic [OSR-1:0][VW-1:0] tally;
    emit_cnt_t              cnt_w;

    assign take = samp_valid & ~burst_start;

    osbr_edge_vote #(.OSR(OSR), .WIN(WIN)) u_vote (
        .clk(clk), .rst_n(rst_n), .clr(burst_start), .take(take),
        .word(samp), .win_end(win_end), .tally(tally)
    );

    osbr_phase_pick #(.OSR(OSR), .WIN(WIN)) u_pick (
        .clk(clk), .rst_n(rst_n), .clr(burst_start), .win_end(win_end),
        .tally(tally), .phase(samp_phase)
    );

    osbr_bit_emit #(.OSR(OSR)) u_emit (
        .clk(clk), .rst_n(rst_n), .clr(burst_start), .take(take),
        .word(samp), .phase(samp_phase), .out_valid(out_valid),
        .out_cnt(cnt_w), .out_bits(out_bits)
    );

    assign out_cnt = cnt_w;
endmodule

// File: rtl/os_burst_rx_chk.sv
`timescale 1ns/1ps
// Checker for os_burst_rx: port-level timing and field rules.
module os_burst_rx_chk #(
    parameter int OSR = 5,
    localparam int PW = $clog2(OSR)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           burst_start,
    input logic           samp_valid,
    input logic           out_valid,
    input logic [1:0]     out_cnt,
    input logic [1:0]     out_bits,
    input logic [PW-1:0]  samp_phase
);
    AST_OUT_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(samp_valid && !burst_start)); // R11
    AST_WORD_GIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !burst_start) |=> out_valid); // R11
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= 2'd2); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_cnt == 2'd0 && out_bits == 2'b00)); // R10
    AST_UNUSED_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cnt != 2'd2) |-> (out_bits[1] == 1'b0)); // R10
    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cnt == 2'd0) |-> (out_bits == 2'b00)); // R6
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(samp_phase) < OSR); // R4
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!samp_valid && !burst_start) |=> $stable(samp_phase)); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (int'(samp_phase) == OSR / 2 && !out_valid)); // R9
endmodule

bind os_burst_rx os_burst_rx_chk #(.OSR(OSR)) u_chk (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
    .samp_valid(samp_valid), .out_valid(out_valid), .out_cnt(out_cnt),
    .out_bits(out_bits), .samp_phase(samp_phase)
);

// File: tb/tb_os_burst_rx.sv
`timescale 1ns/1ps
// Bench for os_burst_rx: behavioural reference model compared every cycle.
module tb_os_burst_rx;
    localparam int OSR = 5;
    localparam int WIN = 8;
    localparam int PW  = $clog2(OSR);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           burst_start = 1'b0;
    logic           samp_valid = 1'b0;
    logic [OSR-1:0] samp = '0;
    logic           out_valid;
    logic [1:0]     out_cnt;
    logic [1:0]     out_bits;
    logic [PW-1:0]  samp_phase;

    always #4 clk = ~clk;

    os_burst_rx #(.OSR(OSR), .WIN(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
        .samp_valid(samp_valid), .samp(samp), .out_valid(out_valid),
        .out_cnt(out_cnt), .out_bits(out_bits), .samp_phase(samp_phase)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Sample stream generator state.
    int sq[$];
    int g_mode = 0;   // 0 zeros, 1 alternating, 2 pseudo-random, 3 ones
    int g_alt = 0;
    int g_drift = 0;  // every 7th bit lasts OSR+g_drift samples
    int g_bitn = 0;
    int lfsr = 16'hACE1;

    // Reference model state.
    int m_votes[OSR];
    int m_win, m_phase, m_used;
    bit m_lastok, m_last;
    logic [OSR-1:0] m_prev;
    int m_ov, m_cnt, m_bits;
    int seen0 = 0;
    int seen2 = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int gen_bit();
        int b;
        case (g_mode)
            1: begin g_alt = 1 - g_alt; b = g_alt; end
            2: begin b = lfsr & 1; lfsr = (lfsr >> 1) ^ ((b != 0) ? 16'hB400 : 0); end
            3: b = 1;
            default: b = 0;
        endcase
        return b;
    endfunction

    task automatic top_up();
        while (sq.size() < OSR) begin
            int b = gen_bit();
            int len = OSR;
            g_bitn++;
            if (g_drift != 0 && (g_bitn % 7) == 0) len = OSR + g_drift;
            repeat (len) sq.push_back(b);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < OSR; k++) m_votes[k] = 0;
        m_win = 0; m_lastok = 0; m_last = 0; m_phase = 2; m_used = 2;
        m_prev = '0; m_ov = 0; m_cnt = 0; m_bits = 0;
    endtask

    task automatic model_step(bit bs, bit v, logic [OSR-1:0] w);
        int e[OSR];
        int tl[OSR];
        if (bs) begin
            model_clear();
        end else if (v) begin
            int p = m_phase;
            for (int k = 0; k < OSR - 1; k++) e[k] = (w[k] != w[k+1]) ? 1 : 0;
            e[OSR-1] = (m_lastok && (m_last != w[0])) ? 1 : 0;
            if (p < m_used && (m_used - p) > 2) begin
                m_cnt = 0; m_bits = 0;
            end else if (p > m_used && (p - m_used) > 2) begin
                m_cnt = 2; m_bits = 2 * int'(w[p]) + int'(m_prev[p]);
            end else begin
                m_cnt = 1; m_bits = int'(w[p]);
            end
            m_ov = 1;
            m_used = p; m_prev = w; m_last = w[OSR-1]; m_lastok = 1;
            for (int k = 0; k < OSR; k++) tl[k] = m_votes[k] + e[k];
            m_win++;
            if (m_win == WIN) begin
                int best = 0;
                int bv = tl[0];
                for (int k = 1; k < OSR; k++) if (tl[k] > bv) begin bv = tl[k]; best = k; end
                if (bv > 0) m_phase = (best + 3) % OSR;
                m_win = 0;
                for (int k = 0; k < OSR; k++) m_votes[k] = 0;
            end else begin
                for (int k = 0; k < OSR; k++) m_votes[k] = tl[k];
            end
        end else begin
            m_ov = 0; m_cnt = 0; m_bits = 0;
        end
    endtask

    // One clock: drive at a falling edge, compare at the next falling edge.
    task automatic cycle(bit bs, bit v);
        logic [OSR-1:0] w = '0;
        if (v && !bs) begin
            top_up();
            for (int i = 0; i < OSR; i++) w[i] = sq.pop_front()[0];
        end
        burst_start = bs; samp_valid = v; samp = w;
        model_step(bs, v, w);
        @(negedge clk);
        chk("R11 out_valid", int'(out_valid), m_ov);
        chk("R8 out_cnt", int'(out_cnt), m_cnt);
        chk("R2/R7 out_bits (R2 R7)", int'(out_bits), m_bits);
        chk("R4 samp_phase", int'(samp_phase), m_phase);
        if (m_ov != 0 && m_cnt == 0) seen0++;
        if (m_ov != 0 && m_cnt == 2) seen2++;
    endtask

    task automatic start_burst(int off, int mode);
        cycle(1'b1, 1'b1);
        chk("R9 phase after burst_start", int'(samp_phase), 2);
        chk("R9 word dropped", int'(out_valid), 0);
        sq.delete();
        repeat (off) sq.push_back(0);
        g_mode = mode; g_alt = 0; g_bitn = 0; g_drift = 0;
    endtask

    initial begin
        int ph;
        model_clear();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset out_cnt", int'(out_cnt), 0);
        chk("R1 reset phase", int'(samp_phase), 2);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0);

        // R3: trained phase per starting offset.
        for (int o = 0; o < OSR; o++) begin
            start_burst(o, 1);
            repeat (2 * WIN) cycle(1'b0, 1'b1);
            chk("R3 trained phase", int'(samp_phase), (o + 2) % OSR);
        end

        // R5: constant data keeps the phase.
        start_burst(1, 1);
        repeat (2 * WIN) cycle(1'b0, 1'b1);
        g_mode = 3;
        repeat (3 * WIN) cycle(1'b0, 1'b1);
        ph = int'(samp_phase);
        repeat (2 * WIN) cycle(1'b0, 1'b1);
        chk("R5 phase held without toggles", int'(samp_phase), ph);

        // R11: random gaps in the word stream.
        start_burst(2, 1);
        repeat (2 * WIN) cycle(1'b0, 1'b1);
        g_mode = 2;
        for (int i = 0; i < 200; i++) cycle(1'b0, ((lfsr >> 3) & 1) != 0 || (i % 3) == 0);

        // R6: data slowly lagging the samples.
        start_burst(2, 1);
        repeat (3 * WIN) cycle(1'b0, 1'b1);
        g_mode = 2; g_drift = 1;
        repeat (700) cycle(1'b0, 1'b1);
        chk("R6 no-bit wrap seen", int'(seen0 > 0), 1);

        // R7: data slowly leading the samples.
        start_burst(3, 1);
        repeat (3 * WIN) cycle(1'b0, 1'b1);
        g_mode = 2; g_drift = -1;
        repeat (700) cycle(1'b0, 1'b1);
        chk("R7 two-bit wrap seen", int'(seen2 > 0), 1);

        // R9: burst start in mid-window.
        repeat (3) cycle(1'b0, 1'b1);
        start_burst(4, 1);
        repeat (2 * WIN) cycle(1'b0, 1'b1);
        chk("R9 fresh burst trains", int'(samp_phase), (4 + 2) % OSR);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule